// File: doc/BRIEF.md
# Programmable Clock Rate Divider

This block derives a slower clock from one input clock. Software writes a divisor code into a field of a single control register through a simple write/read port. A build-time parameter sets how the code is turned into a division ratio. The code can be the ratio minus one, the ratio itself, a power-of-two exponent, or an index into a parameter table in which zero entries mark forbidden codes. The field can sit at any bit offset in the register. Outside table mode, the decoded ratio must lie between a minimum and a maximum divisor.

A write whose code decodes to a forbidden ratio is dropped as a whole. An optional commit mode keeps a newly written code staged and visible on read-back. The running ratio changes only when a write also sets the commit bit. The register also holds an automatic-idle enable bit, whose active level is a parameter, and drives it to an output pin. A new ratio is taken up by the output only at the end of the period in flight, so no phase is ever cut short. The output is never gated.

Top module: `regdiv_clk`

## Requirements
- R1: In minus-one encoding, a field value v selects divide-by-(v+1), subject to the min/max bounds.
- R2: In one-based encoding, a field value v selects divide-by-v. A value of 0 is never accepted.
- R3: In power-of-two encoding, a field value v selects divide-by-2^v, subject to the min/max bounds.
- R4: In table encoding, a field value v selects table entry v. A zero entry, or an index past the table, is never applied.
- R5: The divisor field sits at parameter offset SHIFT of the control register. A read of the control address returns the stored field at that offset and the stored idle bit at its own offset, with every other bit 0, in the same cycle. A read of any other address returns 0, and a write to any other address changes nothing.
- R6: A write whose field decodes to a ratio below the minimum or above the maximum, or to a forbidden code, is ignored. Read-back, idle bit and output ratio all stay unchanged.
- R7: With the commit option on, a valid write that has the commit bit (a parameter position, bit 31 by default) clear updates read-back only. The output keeps its ratio until a valid write sets the commit bit.
- R8: The idle bit written at its parameter offset appears on autoidle_o one cycle after the write. It is inverted when the polarity parameter is set. After reset the stored bit equals the polarity parameter, so autoidle_o is 0.
- R9: A ratio of 1 passes clk_i straight to clk_o.
- R10: For a ratio N of 2 or more, clk_o is high for floor(N/2) input cycles and low for N-floor(N/2) input cycles. A period starts with its high phase.
- R11: A new ratio takes effect only after the last input cycle of the running period. The old period always completes in full.
- R12: After reset, the stored field equals the reset-field parameter and is the running ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | DATA_W | Write data |
| we_i | input | 1 | Write strobe, sampled on the rising edge of clk_i |
| rdata_o | output | DATA_W | Read data for addr_i, combinational |
| clk_o | output | 1 | Divided clock |
| autoidle_o | output | 1 | Automatic-idle enable, polarity corrected |

## Verification
Read-back is combinational and the idle output is registered, so both are checked on the falling edge that follows the capturing rising edge. A ratio change completes at most one old period after the write. The bench therefore waits longer than the largest possible period, then locks onto a rising edge of clk_o and counts high and low phases with samples taken 1 ns after each input rising edge. One directed case writes exactly one cycle into a period and compares every later sample with the exact cycle-by-cycle pattern: the remainder of the old period, then the new one.

// File: rtl/regdiv_pkg.sv
package regdiv_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    // How a stored divisor field is turned into a division ratio
    typedef enum logic [1:0] {
        ENC_MINUS1  = 2'd0,
        ENC_DIRECT  = 2'd1,
        ENC_POW2    = 2'd2,
        ENC_TABLE   = 2'd3
    } div_enc_e;
endpackage

// File: rtl/regdiv_decode.sv
module regdiv_decode
    import regdiv_pkg::*;
#(
    parameter div_enc_e              MODE    = ENC_MINUS1,
    parameter int                    FIELD_W = 7,
    parameter int                    CNT_W   = 8,
    parameter int                    MIN_DIV = 1,
    parameter int                    MAX_DIV = 127,
    parameter int                    TBL_N   = 4,
    parameter logic [TBL_N*CNT_W-1:0] TABLE  = '0
) (
    input  logic [FIELD_W-1:0] field_i,
    output logic [CNT_W-1:0]   div_o,
    output logic               valid_o
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [31:0] ratio;

    generate
        if (MODE == ENC_TABLE) begin : g_table
            always_comb begin
                ratio = 32'd0;
                for (int i = 0; i < TBL_N; i++) begin
                    if (32'(field_i) == i) ratio = 32'(TABLE[i*CNT_W +: CNT_W]);
                end
            end
            assign valid_o = (ratio != 32'd0);
        end else begin : g_arith
            if (MODE == ENC_MINUS1) begin : g_m1
                assign ratio = 32'(field_i) + 32'd1;
            end else if (MODE == ENC_DIRECT) begin : g_dir
                assign ratio = 32'(field_i);
            end else begin : g_pow
                assign ratio = (32'(field_i) < CNT_W) ? (32'd1 << field_i) : 32'd0;
            end
            assign valid_o = (ratio != 32'd0) && (ratio >= 32'(MIN_DIV)) &&
                             (ratio <= 32'(MAX_DIV));
        end
    endgenerate

    assign div_o = ratio[CNT_W-1:0];
endmodule

// File: rtl/regdiv_regs.sv
module regdiv_regs
    import regdiv_pkg::*;
#(
    parameter int                    ADDR_W    = 4,
    parameter int                    DATA_W    = 32,
    parameter int                    CTRL_ADDR = 0,
    parameter div_enc_e              MODE      = ENC_MINUS1,
    parameter int                    FIELD_W   = 7,
    parameter int                    SHIFT     = 0,
    parameter int                    CNT_W     = 8,
    parameter int                    MIN_DIV   = 1,
    parameter int                    MAX_DIV   = 127,
    parameter int                    TBL_N     = 4,
    parameter logic [TBL_N*CNT_W-1:0] TABLE    = '0,
    parameter int                    LATCH_EN  = 0,
    parameter int                    LATCH_BIT = 31,
    parameter int                    AI_BIT    = 30,
    parameter int                    AI_INV    = 0,
    parameter int                    RST_FIELD = 0
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic               we_i,
    output logic [DATA_W-1:0]  rdata_o,
    output logic [FIELD_W-1:0] act_field_o,
    output logic               autoidle_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [ADDR_W-1:0]  CTRL_A   = ADDR_W'(CTRL_ADDR);
    localparam logic [FIELD_W-1:0] RST_F    = FIELD_W'(RST_FIELD);
    localparam logic               RST_AI   = (AI_INV != 0);

    typedef struct packed {
        logic [FIELD_W-1:0] stg;
        logic [FIELD_W-1:0] act;
        logic               ai;
    } regs_t;

    regs_t st_d, st_q;

    logic               hit;
    logic [FIELD_W-1:0] wr_fld;
    logic               wr_ok;
    logic [CNT_W-1:0]   wr_div;
    logic               commit;

    assign hit    = we_i && (addr_i == CTRL_A);
    assign wr_fld = FIELD_W'(wdata_i >> SHIFT);
    assign commit = (LATCH_EN == 0) || wdata_i[LATCH_BIT];

    regdiv_decode #(
        .MODE(MODE), .FIELD_W(FIELD_W), .CNT_W(CNT_W), .MIN_DIV(MIN_DIV),
        .MAX_DIV(MAX_DIV), .TBL_N(TBL_N), .TABLE(TABLE)
    ) u_wr_dec (
        .field_i (wr_fld),
        .div_o   (wr_div),
        .valid_o (wr_ok)
    );

    always_comb begin
        st_d = st_q;
        if (hit && wr_ok) begin
            st_d.stg = wr_fld;
            st_d.ai  = wdata_i[AI_BIT];
            if (commit) st_d.act = wr_fld;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{stg: RST_F, act: RST_F, ai: RST_AI};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == CTRL_A) begin
            rdata_o = (DATA_W'(st_q.stg) << SHIFT) | (DATA_W'(st_q.ai) << AI_BIT);
        end
    end

    assign act_field_o = st_q.act;
    assign autoidle_o  = st_q.ai ^ RST_AI;

    // R6
    bad_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hit && !wr_ok) |=> ($stable(st_q.stg) && $stable(st_q.act) && $stable(st_q.ai)));

    // R7
    staged_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((LATCH_EN != 0) && hit && !wdata_i[LATCH_BIT]) |=> $stable(st_q.act));

    // R5
    other_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && (addr_i != CTRL_A)) |=> $stable(st_q));

    logic unused_div;
    assign unused_div = ^wr_div;
endmodule

// File: rtl/regdiv_gen.sv
module regdiv_gen #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] tgt_div_i,
    output logic             clk_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] run;
        logic             out;
    } gen_t;

    gen_t st_d, st_q;
    logic last;

    assign last = (st_q.cnt == st_q.run - ONE);

    always_comb begin
        st_d = st_q;
        if (last) begin
            st_d.cnt = '0;
            st_d.run = tgt_div_i;
        end else begin
            st_d.cnt = st_q.cnt + ONE;
        end
        st_d.out = (st_d.cnt < (st_d.run >> 1));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{cnt: '0, run: ONE, out: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign clk_o = (st_q.run == ONE) ? clk_i : st_q.out;

    // R11
    ratio_at_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.run != $past(st_q.run)) |-> ($past(st_q.cnt) == $past(st_q.run) - ONE));

    // R10
    rise_at_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.out) |-> (st_q.cnt == '0));

    // R10
    cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.run != '0) && (st_q.cnt < st_q.run));
endmodule

// File: rtl/regdiv_clk.sv
module regdiv_clk
    import regdiv_pkg::*;
#(
    parameter int                    ADDR_W    = 4,
    parameter int                    DATA_W    = 32,
    parameter int                    CTRL_ADDR = 0,
    parameter div_enc_e              MODE      = ENC_MINUS1,
    parameter int                    FIELD_W   = 7,
    parameter int                    SHIFT     = 0,
    parameter int                    CNT_W     = 8,
    parameter int                    MIN_DIV   = 1,
    parameter int                    MAX_DIV   = 127,
    parameter int                    TBL_N     = 4,
    parameter logic [TBL_N*CNT_W-1:0] TABLE    = {8'd16, 8'd0, 8'd8, 8'd4},
    parameter int                    LATCH_EN  = 0,
    parameter int                    LATCH_BIT = 31,
    parameter int                    AI_BIT    = 30,
    parameter int                    AI_INV    = 0,
    parameter int                    RST_FIELD = 0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              we_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              clk_o,
    output logic              autoidle_o
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [FIELD_W-1:0] act_field;
    logic [CNT_W-1:0]   act_div;
    logic               act_ok;

    regdiv_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR), .MODE(MODE),
        .FIELD_W(FIELD_W), .SHIFT(SHIFT), .CNT_W(CNT_W), .MIN_DIV(MIN_DIV),
        .MAX_DIV(MAX_DIV), .TBL_N(TBL_N), .TABLE(TABLE), .LATCH_EN(LATCH_EN),
        .LATCH_BIT(LATCH_BIT), .AI_BIT(AI_BIT), .AI_INV(AI_INV),
        .RST_FIELD(RST_FIELD)
    ) u_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .addr_i      (addr_i),
        .wdata_i     (wdata_i),
        .we_i        (we_i),
        .rdata_o     (rdata_o),
        .act_field_o (act_field),
        .autoidle_o  (autoidle_o)
    );

    regdiv_decode #(
        .MODE(MODE), .FIELD_W(FIELD_W), .CNT_W(CNT_W), .MIN_DIV(MIN_DIV),
        .MAX_DIV(MAX_DIV), .TBL_N(TBL_N), .TABLE(TABLE)
    ) u_act_dec (
        .field_i (act_field),
        .div_o   (act_div),
        .valid_o (act_ok)
    );

    regdiv_gen #(
        .CNT_W(CNT_W)
    ) u_gen (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tgt_div_i (act_div),
        .clk_o     (clk_o)
    );

    // R4
    active_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        act_ok && (act_div != '0));
endmodule

// File: tb/regdiv_clk_tb.sv
module regdiv_clk_tb;
    timeunit 1ns;
    timeprecision 1ps;
    import regdiv_pkg::*;

    logic        clk;
    logic        rst_n;
    logic [3:0]  addr;
    logic [31:0] wdata;
    logic [3:0]  we;
    logic [31:0] rdata [4];
    logic [3:0]  clko;
    logic [3:0]  aio;

    int checks = 0;
    int errors = 0;

    // per-instance build settings, mirrored from the requirements
    int SH  [4] = '{8, 24, 4, 0};
    int FW  [4] = '{7, 7, 3, 2};
    int AIB [4] = '{24, 0, 0, 8};
    int INV [4] = '{1, 0, 0, 0};
    string REQ [4] = '{"R1", "R2", "R3", "R4"};

    int exp_stg [4];
    int exp_act [4];
    int exp_ai  [4];

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    regdiv_clk #(.MODE(ENC_MINUS1), .FIELD_W(7), .SHIFT(8), .MIN_DIV(2), .MAX_DIV(31),
        .LATCH_EN(1), .LATCH_BIT(31), .AI_BIT(24), .AI_INV(1), .RST_FIELD(1)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we[0]),
        .rdata_o(rdata[0]), .clk_o(clko[0]), .autoidle_o(aio[0]));

    regdiv_clk #(.MODE(ENC_DIRECT), .FIELD_W(7), .SHIFT(24), .MIN_DIV(1), .MAX_DIV(127),
        .AI_BIT(0), .RST_FIELD(1)) u_dut_dir (
        .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we[1]),
        .rdata_o(rdata[1]), .clk_o(clko[1]), .autoidle_o(aio[1]));

    regdiv_clk #(.MODE(ENC_POW2), .FIELD_W(3), .SHIFT(4), .MIN_DIV(1), .MAX_DIV(8),
        .AI_BIT(0), .RST_FIELD(0)) u_dut_pow (
        .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we[2]),
        .rdata_o(rdata[2]), .clk_o(clko[2]), .autoidle_o(aio[2]));

    regdiv_clk #(.MODE(ENC_TABLE), .FIELD_W(2), .SHIFT(0), .TBL_N(4),
        .TABLE({8'd16, 8'd0, 8'd8, 8'd4}), .AI_BIT(8), .RST_FIELD(0)) u_dut_tbl (
        .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we[3]),
        .rdata_o(rdata[3]), .clk_o(clko[3]), .autoidle_o(aio[3]));

    // ratio implied by a field value; 0 means the value is refused
    function automatic int bdec(int k, int f);
        int d;
        case (k)
            0: begin d = f + 1; if (d < 2 || d > 31) d = 0; end
            1: begin d = f;     if (d < 1 || d > 127) d = 0; end
            2: begin d = (f < 8) ? (1 << f) : 0; if (d > 8) d = 0; end
            default: case (f) 0: d = 4; 1: d = 8; 3: d = 16; default: d = 0; endcase
        endcase
        return d;
    endfunction

    function automatic logic [31:0] exp_rd(int k);
        return (32'(exp_stg[k]) << SH[k]) | (32'(exp_ai[k]) << AIB[k]);
    endfunction

    task automatic chk(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic wr(int k, logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 4'b0; we[k] = 1'b1;
        @(negedge clk);
        we = 4'b0;
    endtask

    // write a field plus idle bit (and commit bit) to instance k, update the model
    task automatic wfield(int k, int f, int ai, int commit);
        logic [31:0] d;
        d = (32'(f) << SH[k]) | (32'(ai) << AIB[k]) | (32'(commit) << 31);
        wr(k, 4'd0, d);
        if (bdec(k, f) != 0) begin
            exp_stg[k] = f;
            exp_ai[k]  = ai;
            if (k != 0 || commit != 0) exp_act[k] = f;
        end
    endtask

    task automatic meas(int k, output int hi, output int lo);
        int prev = 1;
        int n = 0;
        hi = -1; lo = -1;
        forever begin
            @(posedge clk); #1;
            n++;
            if (prev == 0 && clko[k] == 1'b1) break;
            prev = int'(clko[k]);
            if (n > 600) return;
        end
        hi = 1;
        forever begin
            @(posedge clk); #1;
            if (clko[k] == 1'b1) hi++; else break;
            if (hi > 300) return;
        end
        lo = 1;
        forever begin
            @(posedge clk); #1;
            if (clko[k] == 1'b0) lo++; else break;
            if (lo > 300) return;
        end
    endtask

    task automatic check_regs(int k, string req);
        addr = 4'd0; #1;
        chk({req, " R5 readback"}, int'(rdata[k]), int'(exp_rd(k)));
        chk({req, " R8 autoidle"}, int'(aio[k]), exp_ai[k] ^ INV[k]);
    endtask

    task automatic check_out(int k, string req);
        int n, hi, lo;
        n = bdec(k, exp_act[k]);
        repeat (270) @(posedge clk);
        meas(k, hi, lo);
        if (n == 1) begin
            chk({req, " R9 no divided edge"}, hi, -1);
            @(negedge clk); #1;
            chk({req, " R9 low follows"}, int'(clko[k]), 0);
            @(posedge clk); #1;
            chk({req, " R9 high follows"}, int'(clko[k]), 1);
        end else begin
            chk({req, " R10 high phase"}, hi, n / 2);
            chk({req, " R10 low phase"}, lo, n - n / 2);
        end
    endtask

    initial begin
        #900000;
        errors++;
        $display("FAIL watchdog: got %0d expected %0d", checks, -1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        addr = '0; wdata = '0; we = '0; rst_n = 1'b0;
        exp_stg = '{1, 1, 0, 0};
        exp_act = '{1, 1, 0, 0};
        exp_ai  = '{1, 0, 0, 0};
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R12 reset state of every instance
        for (int k = 0; k < 4; k++) begin
            check_regs(k, "R12");
            check_out(k, "R12");
        end

        // R6 below minimum and above maximum on the minus-one instance
        wfield(0, 0, 0, 1);
        check_regs(0, "R6");
        wfield(0, 40, 0, 1);
        check_regs(0, "R6");
        check_out(0, "R6");

        // R7 staged write without commit, then commit
        wfield(0, 5, 0, 0);
        check_regs(0, "R7");
        check_out(0, "R7");
        wfield(0, 5, 0, 1);
        check_out(0, "R7");

        // R5 other address: read gives 0, write changes nothing
        addr = 4'd3; #1;
        chk("R5 other read", int'(rdata[0]), 0);
        wr(0, 4'd3, 32'h8000_0300);
        check_regs(0, "R5");

        // R2/R9 passthrough, R3 refused exponent, R4 zero entry
        wfield(1, 1, 1, 0);
        check_out(1, "R2");
        wfield(2, 4, 1, 0);
        check_regs(2, "R3");
        wfield(3, 2, 1, 0);
        check_regs(3, "R4");
        check_out(3, "R4");

        // R11 change one cycle into a period: old period completes, then new
        wfield(3, 0, 0, 0);
        repeat (300) @(posedge clk);
        begin
            int prev = 1;
            int bad = 0;
            forever begin
                @(posedge clk); #1;
                if (prev == 0 && clko[3] == 1'b1) break;
                prev = int'(clko[3]);
            end
            addr = 4'd0; wdata = 32'd3; we = 4'b1000;
            for (int i = 1; i < 40; i++) begin
                int e;
                @(posedge clk); #1;
                we = 4'b0;
                e = (i < 4) ? int'(i < 2) : int'(((i - 4) % 16) < 8);
                if (int'(clko[3]) != e) bad++;
            end
            chk("R11 transition pattern", bad, 0);
            exp_stg[3] = 3; exp_act[3] = 3;
        end

        // constrained random writes across all encodings
        for (int it = 0; it < 24; it++) begin
            int k, f, ai, c;
            k  = int'($urandom % 4);
            f  = int'($urandom % (1 << FW[k]));
            ai = int'($urandom % 2);
            c  = int'($urandom % 2);
            wfield(k, f, ai, c);
            check_regs(k, REQ[k]);
            check_out(k, REQ[k]);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule